// File: doc/BRIEF.md
# Cache Tag and Replacement Controller with Selectable Associativity

This block holds the tag, valid and recency state of a small cache of four block entries. The same four entries can be arranged as one way per set (direct-mapped), two ways per set, or a single set of four ways (fully associative). The choice is made by a parameter. Data storage, dirty data and the path to memory belong to other blocks.

A lookup presents a block address with `req_valid` for one cycle. The set is the block address modulo the number of sets, and the tag is the remaining upper bits. All ways of that set are compared at once. On the next cycle the block reports hit or miss, and it reports either the way that hit or the way chosen for the fill. On a miss the chosen way is filled with the new tag in the same cycle. A lookup is accepted on every cycle. There is no back-pressure on either side: the result is a one-cycle status pulse that the neighbouring data array must take as it comes.

Top module: `ctag_ctrl`

## Requirements
- R1: While `rst_n` is low, every entry is cleared to invalid and the recency state is cleared. The first cycle after reset shows `rsp_valid` low, and any address looked up after reset misses.
- R2: The set index is the block address modulo SETS = ENTRIES/WAYS, taken from the low log2(SETS) address bits. The tag is the upper ADDR_W - log2(SETS) bits. A lookup hits only if a valid way in that set holds that tag.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high.
- R4: On a hit, `rsp_hit` is 1 and `rsp_way` is the number of the way that holds the tag.
- R5: On a miss where the set still has invalid ways, the lowest-numbered invalid way is filled and reported in `rsp_way`. `rsp_hit` is 0.
- R6: On a miss where every way in the set is valid, the least recently used way is filled and reported.
- R7: Both a hit and a fill make the accessed way the most recently used way of its set.
- R8: With WAYS=1, `rsp_way` is always 0, and a miss always replaces the single entry at the index.
- R9: For block addresses 0, 8, 0, 6, 8 looked up after reset, the results are as follows. Direct-mapped gives miss, miss, miss, miss, miss. Two-way gives miss, miss, hit, miss, miss. Fully associative gives miss, miss, hit, miss, hit.
- R10: A cycle with `req_valid` low changes no tag, valid or recency state, and it gives `rsp_valid`=0 and `rsp_hit`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | ADDR_W | Block address of the lookup |
| rsp_valid | output | 1 | Result of the previous cycle's lookup |
| rsp_hit | output | 1 | 1 = hit, 0 = miss (filled) |
| rsp_way | output | max(1,log2(WAYS)) | Way that hit, or way that was filled |

## Verification
Each result is due one clock after its request: `rsp_valid`, `rsp_hit` and `rsp_way` are registered at the same edge that updates the tags and recency state. The bench therefore drives a request on a falling edge. On the following falling edge it compares all three outputs against a timestamp-based reference model that has already been advanced for that request. Three instances, one per associativity, receive the same stimulus. The fixed 0, 8, 0, 6, 8 sequence is also compared against literal hit patterns.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
  // Width of an index over n items, never below one bit.
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ctag_match.sv
// Parallel tag comparison across all ways of one set.
module ctag_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 7
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_vld,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_vld[w] && (set_tags[w] == key);
  end
endmodule

// File: rtl/ctag_lru.sv
// Recency ranks for one set: rank 0 = most recent, WAYS-1 = least recent.
module ctag_lru #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][WAY_W-1:0]  rank
);
  logic [WAY_W-1:0] cur;

  always_comb begin
    cur = '0;
    for (int w = 0; w < WAYS; w++)
      if (touch_way == WAY_W'(w)) cur = rank[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) rank[w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (touch_way == WAY_W'(w))
          rank[w] <= '0;
        else if (rank[w] < cur)
          rank[w] <= rank[w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctag_victim.sv
// Fill choice: lowest invalid way, else the way of oldest rank.
module ctag_victim #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]             set_vld,
  input  logic [WAYS-1:0][WAY_W-1:0]  rank,
  output logic [WAY_W-1:0]            victim
);
  logic found;

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !set_vld[w]) begin
        victim = WAY_W'(w);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (rank[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/ctag_ctrl.sv
module ctag_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int ENTRIES = 4,
  parameter int WAYS    = 2,
  localparam int WAY_W  = ctag_pkg::idx_bits(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int IDX_W = ctag_pkg::idx_bits(SETS);
  localparam int TAG_W = ADDR_W - SET_W;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            vld_q;
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_all;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] key;
  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] acc_way;

  if (SETS > 1) begin : g_idx
    assign idx = req_addr[SET_W-1:0];
  end else begin : g_noidx
    assign idx = '0;
  end
  assign key = req_addr[ADDR_W-1:SET_W];

  ctag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .set_tags (tag_q[idx]),
    .set_vld  (vld_q[idx]),
    .key      (key),
    .hit_vec  (hit_vec)
  );

  ctag_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .set_vld (vld_q[idx]),
    .rank    (rank_all[idx]),
    .victim  (victim)
  );

  always_comb begin
    hit     = |hit_vec;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign acc_way = hit ? hit_way : victim;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    ctag_lru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (req_valid && (idx == IDX_W'(s))),
      .touch_way (acc_way),
      .rank      (rank_all[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      tag_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      rsp_way   <= req_valid ? acc_way : '0;
      if (req_valid && !hit) begin
        tag_q[idx][victim] <= key;
        vld_q[idx][victim] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctag_ctrl_chk.sv
module ctag_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int WAYS   = 2,
  parameter int WAY_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way
);
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid)); // R3

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit); // R10

  AST_WAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(rsp_way) < WAYS)); // R5

  AST_REPEAT_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && req_addr == $past(req_addr)) |=> rsp_hit); // R7

  if (WAYS == 1) begin : g_dm
    AST_DM_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_way == '0)); // R8
  end
endmodule

bind ctag_ctrl ctag_ctrl_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way)
);

// File: tb/tb_ctag_ctrl.sv
module tb_ctag_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_addr = '0;
  always #2.5 clk = ~clk;

  logic       v0, v1, v2, h0, h1, h2;
  logic [0:0] w0, w1;
  logic [1:0] w2;

  ctag_ctrl #(.WAYS(1)) dut_dm (.clk, .rst_n, .req_valid, .req_addr,
    .rsp_valid(v0), .rsp_hit(h0), .rsp_way(w0));
  ctag_ctrl #(.WAYS(2)) dut    (.clk, .rst_n, .req_valid, .req_addr,
    .rsp_valid(v1), .rsp_hit(h1), .rsp_way(w1));
  ctag_ctrl #(.WAYS(4)) dut_fa (.clk, .rst_n, .req_valid, .req_addr,
    .rsp_valid(v2), .rsp_hit(h2), .rsp_way(w2));

  int checks = 0, failures = 0;
  int mtag [3][4][4];
  bit mval [3][4][4];
  int mts  [3][4][4];
  int now = 0;
  bit exp_v;
  bit exp_h [3];
  int exp_w [3];
  string exp_tag [3];
  bit cap_h [3];

  function automatic int ways_of(int c); return 1 << c; endfunction

  task automatic chk(string r, int c, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s cfg_ways=%0d got=%0d exp=%0d", r, ways_of(c), got, exp);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 4; w++) mval[c][s][w] = 0;
    exp_v = 0;
  endtask

  task automatic model_access(int c, int a);
    int nw, ns, s, t, way, oldest;
    bit h;
    nw = ways_of(c); ns = 4 / nw; s = a % ns; t = a / ns;
    h = 0; way = -1;
    for (int w = 0; w < nw; w++) if (mval[c][s][w] && mtag[c][s][w] == t) begin h = 1; way = w; end
    if (h) exp_tag[c] = "R4";
    else begin
      for (int w = nw - 1; w >= 0; w--) if (!mval[c][s][w]) way = w;
      if (way >= 0) exp_tag[c] = "R5";
      else begin
        exp_tag[c] = "R6";
        oldest = 0;
        for (int w = 1; w < nw; w++) if (mts[c][s][w] < mts[c][s][oldest]) oldest = w;
        way = oldest;
      end
      mval[c][s][way] = 1; mtag[c][s][way] = t;
    end
    mts[c][s][way] = now;
    exp_h[c] = h; exp_w[c] = way;
  endtask

  // Compare results of the previous cycle's request, then drive this cycle.
  task automatic step(bit v, int a, string lbl);
    bit gv [3]; bit gh [3]; int gw [3];
    @(negedge clk);
    gv[0] = v0; gv[1] = v1; gv[2] = v2;
    gh[0] = h0; gh[1] = h1; gh[2] = h2;
    gw[0] = int'(w0); gw[1] = int'(w1); gw[2] = int'(w2);
    for (int c = 0; c < 3; c++) begin
      cap_h[c] = gh[c];
      chk(exp_v ? "R3" : "R10", c, gv[c], exp_v);
      if (exp_v) begin
        chk(exp_tag[c] == "R4" ? "R4" : lbl, c, gh[c], exp_h[c]);
        chk(exp_tag[c], c, gw[c], exp_w[c]);
      end else chk("R10", c, gh[c], 0);
    end
    if (exp_v) chk("R8", 0, gw[0], 0);
    req_valid = v; req_addr = 8'(a);
    exp_v = v;
    if (v) begin
      now++;
      for (int c = 0; c < 3; c++) model_access(c, a);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 0; rst_n = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 0, v0, 0); chk("R1", 1, v1, 0); chk("R1", 2, v2, 0);
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seq [5] = '{0, 8, 0, 6, 8};
    bit got [3][5];
    bit exp9 [3][5] = '{'{0,0,0,0,0}, '{0,0,1,0,0}, '{0,0,1,0,1}};
    int a;
    model_clear();
    do_reset();

    // R9: reference block sequence in each layout
    for (int i = 0; i < 6; i++) begin
      step(i < 5, (i < 5) ? seq[i] : 0, "R9");
      if (i > 0) for (int c = 0; c < 3; c++) got[c][i-1] = cap_h[c];
    end
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 5; i++) chk("R9", c, got[c][i], exp9[c][i]);

    // R10: idle cycles leave state untouched, then revisit
    repeat (4) step(0, 0, "R10");
    step(1, 8, "R10"); step(1, 6, "R10"); step(0, 0, "R10");

    // R6/R7: fill set 0 fully, refresh oldest, then force replacement
    do_reset();
    step(1, 4, "R5"); step(1, 8, "R5"); step(1, 12, "R5"); step(1, 16, "R5");
    step(1, 4, "R7"); step(1, 20, "R6"); step(1, 4, "R7"); step(1, 8, "R6");
    step(0, 0, "R10");

    // R2: pseudo-random addresses over a small range to mix hits and misses
    a = 3;
    for (int i = 0; i < 400; i++) begin
      a = (a * 37 + 11) % 251;
      step((i % 7) != 3, a % 24, "R2");
    end
    step(0, 0, "R10");

    // R1: reset mid-run invalidates a resident block
    step(1, 7, "R5"); step(1, 7, "R4"); step(0, 0, "R10");
    do_reset();
    step(1, 7, "R1"); step(0, 0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule